// File: doc/BRIEF.md
# Memory-to-memory DMA channel

This block is one copy channel of a DMA controller. Software programs it through a 32-bit register window: a source address, a destination address, a unit count and a command word. It then sets the channel enable bit. The engine moves data over a single-beat memory master port. Each beat is a read from the source followed by a write to the destination. Each address advances after a beat only when its increment bit is set. The count drops by one for every whole unit moved.

When the count reaches zero, the channel raises its completed flag. If the interrupt is enabled, it also sets its bit in a shared interrupt-pending register, which drives the `irq` output. A global control register holds the controller enable. It also mirrors every address-error and halt event that the channel records in its own control/status register. Clearing the global enable during a copy halts the channel at the next beat boundary.

Top module: `dmach_top`

## Requirements
- R1: After a synchronous reset, every register reads 0, `irq` is low and `mem_req` is low.
- R2: Register byte offsets are: source address 0x000, destination address 0x004, count 0x008, request type 0x00C (6 bits kept), control/status 0x010, command 0x014, global control 0x1000 and interrupt pending 0x1004. Offsets 0x018 and 0x01C read 0. The command keeps only bits 23, 22, 15:12, 11:8 and 1, so it reads back masked with 0x00C0FF02.
- R3: A copy starts only on a write of 1 to control/status bit 0 while all of the following hold: the channel is idle, the completed (bit 3), halted (bit 2) and error (bit 4) flags are already clear, the count is nonzero, and global control bit 0 is set. A start that is refused makes no memory access and leaves bit 0 reading 0. Bit 0 reads 1 exactly while a copy runs.
- R4: Port-width codes (source in command bits 15:14, destination in bits 13:12) are 1 for 8-bit, 2 for 16-bit and anything else for 32-bit. Each beat moves min(source width, destination width, unit size) bytes: a read from the source, then a write of the same size to the destination. Data is little-endian and right-justified. `mem_size` is 0, 1 or 2 for 1, 2 or 4 bytes.
- R5: After each beat, command bit 23 set advances the source by the beat size and bit 22 set advances the destination. When a bit is clear, that address stays fixed.
- R6: Unit size codes in command bits 11:8 are 1 for 1 byte, 2 for 2 bytes, 3 for 16, 4 for 32, 5 for 64 and 6 for 128 bytes. Every other code, including 7, is a 4-byte unit. The count decrements once per whole unit.
- R7: When the count reaches 0, the control/status register reads completed (bit 3) with bit 0 clear. If command bit 1 is set, the channel's pending bit (`CH_IDX`) is set and `irq` goes high. Otherwise both stay low.
- R8: Writing 0 to the channel's pending bit clears it. Writing 1 to it never sets it.
- R9: The completed, halted and error flags, and global bits 2 and 3, clear when written 0 and are unchanged when written 1.
- R10: A source address misaligned to the source port width, or a destination address misaligned to the destination port width, is checked at start. It sets control/status bit 4 and global bit 2 and clears bit 0. No memory access is made and the count is left unchanged.
- R11: Clearing global bit 0 during a copy stops it before the next beat. This sets control/status bit 2 and global bit 3, clears bit 0, and leaves the count holding the units not yet moved.
- R12: Writes to the source, destination, count, request type or command register are ignored while a copy runs.
- R13: The count holds `CNT_W` bits (24 by default), upper bits read 0, and the count reads 0 after a completed copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 13 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_size | output | 2 | Beat size, log2 bytes |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_ack | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 32 | Read data, right-justified |
| irq | output | 1 | Channel interrupt pending |

## Verification
The bench builds the channel with `CH_IDX` = 5 rather than 0. This exposes any mistake in where the pending bit lands and in which write-data bit clears it. It keeps the default 24-bit count, so an all-ones write shows the upper byte truncated. A table of copies covers every unit size class, mixed port widths, and fixed source or destination. A reference model of the beat sequence predicts the resulting memory image, and directed runs cover refused starts, misalignment, halting and writes made during a run.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int REG_AW = 13;
    localparam int UB_W   = 8;   // holds up to 128 bytes per unit

    localparam logic [REG_AW-1:0] OFS_SRC  = 13'h000;
    localparam logic [REG_AW-1:0] OFS_DST  = 13'h004;
    localparam logic [REG_AW-1:0] OFS_CNT  = 13'h008;
    localparam logic [REG_AW-1:0] OFS_REQ  = 13'h00C;
    localparam logic [REG_AW-1:0] OFS_CS   = 13'h010;
    localparam logic [REG_AW-1:0] OFS_CMD  = 13'h014;
    localparam logic [REG_AW-1:0] OFS_GCTL = 13'h1000;
    localparam logic [REG_AW-1:0] OFS_PEND = 13'h1004;

    localparam logic [31:0] CMD_KEEP = 32'h00C0_FF02;

    localparam int CS_EN     = 0;
    localparam int CS_HALT   = 2;
    localparam int CS_DONE   = 3;
    localparam int CS_ERR    = 4;
    localparam int CS_NODESC = 31;
    localparam int G_EN      = 0;
    localparam int G_ERR     = 2;
    localparam int G_HALT    = 3;

    typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_RD, ST_WR} eng_state_t;

    typedef struct packed {
        logic       src_inc;
        logic       dst_inc;
        logic [1:0] src_w;
        logic [1:0] dst_w;
        logic [3:0] unit;
        logic       irq_en;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [31:0] w);
        cmd_t c;
        c.src_inc = w[23];
        c.dst_inc = w[22];
        c.src_w   = w[15:14];
        c.dst_w   = w[13:12];
        c.unit    = w[11:8];
        c.irq_en  = w[1];
        return c;
    endfunction

    // log2 of the port width in bytes
    function automatic logic [1:0] port_lg(input logic [1:0] code);
        case (code)
            2'd1:    return 2'd0;
            2'd2:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // log2 of the unit size in bytes
    function automatic logic [2:0] unit_lg(input logic [3:0] code);
        case (code)
            4'd1:    return 3'd0;
            4'd2:    return 3'd1;
            4'd3:    return 3'd4;
            4'd4:    return 3'd5;
            4'd5:    return 3'd6;
            4'd6:    return 3'd7;
            default: return 3'd2;
        endcase
    endfunction

    // low address bits that must be zero for a given log2 width
    function automatic logic [1:0] lg_mask(input logic [1:0] lg);
        case (lg)
            2'd0:    return 2'b00;
            2'd1:    return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/dmach_engine.sv
module dmach_engine
    import dmach_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          gen_en,
    input  cmd_t          cmd,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [CW-1:0] cnt,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    output logic          busy,
    output logic          src_upd,
    output logic          dst_upd,
    output logic [AW-1:0] src_nxt,
    output logic [AW-1:0] dst_nxt,
    output logic          cnt_dec,
    output logic          fin_done,
    output logic          fin_err,
    output logic          fin_halt
);

    eng_state_t      st;
    logic [UB_W-1:0] left_q;
    logic [31:0]     hold_q;
    logic            first_q;

    logic [1:0]      s_lg, d_lg, b_lg;
    logic [2:0]      u_lg;
    logic [UB_W-1:0] beat_b, unit_b;
    logic            misal, wr_ack, unit_end;

    always_comb begin
        s_lg = port_lg(cmd.src_w);
        d_lg = port_lg(cmd.dst_w);
        u_lg = unit_lg(cmd.unit);
        b_lg = (s_lg < d_lg) ? s_lg : d_lg;
        if ({1'b0, b_lg} > u_lg) b_lg = u_lg[1:0];
        beat_b = UB_W'(1) << b_lg;
        unit_b = UB_W'(1) << u_lg;
        misal  = (|(src[1:0] & lg_mask(s_lg))) | (|(dst[1:0] & lg_mask(d_lg)));
    end

    always_comb begin
        busy      = (st != ST_IDLE);
        mem_req   = (st == ST_RD) || (st == ST_WR);
        mem_we    = (st == ST_WR);
        mem_addr  = (st == ST_WR) ? dst : src;
        mem_size  = b_lg;
        mem_wdata = hold_q;
        wr_ack    = (st == ST_WR) && mem_ack;
        unit_end  = wr_ack && (left_q == beat_b);
        src_upd   = wr_ack && cmd.src_inc;
        dst_upd   = wr_ack && cmd.dst_inc;
        src_nxt   = src + AW'(beat_b);
        dst_nxt   = dst + AW'(beat_b);
        cnt_dec   = unit_end;
        fin_done  = unit_end && (cnt == CW'(1));
        fin_halt  = (st == ST_CHK) && !gen_en;
        fin_err   = (st == ST_CHK) && gen_en && first_q && misal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            left_q  <= '0;
            hold_q  <= '0;
            first_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st      <= ST_CHK;
                    left_q  <= unit_b;
                    first_q <= 1'b1;
                end
                ST_CHK: if (fin_halt || fin_err) begin
                    st <= ST_IDLE;
                end else begin
                    st      <= ST_RD;
                    first_q <= 1'b0;
                end
                ST_RD: if (mem_ack) begin
                    hold_q <= mem_rdata;
                    st     <= ST_WR;
                end
                ST_WR: if (mem_ack) begin
                    st     <= fin_done ? ST_IDLE : ST_CHK;
                    left_q <= unit_end ? unit_b : left_q - beat_b;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R4
    beat_size_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_size <= port_lg(cmd.src_w)) && (mem_size <= port_lg(cmd.dst_w)));

    // R6
    unit_left_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> left_q != '0);

endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int AW     = 32,
    parameter int CW     = 24,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              src_upd,
    input  logic              dst_upd,
    input  logic [AW-1:0]     src_nxt,
    input  logic [AW-1:0]     dst_nxt,
    input  logic              cnt_dec,
    input  logic              fin_done,
    input  logic              fin_err,
    input  logic              fin_halt,
    output logic [AW-1:0]     src_q,
    output logic [AW-1:0]     dst_q,
    output logic [CW-1:0]     cnt_q,
    output cmd_t              cmd,
    output logic              g_en,
    output logic              start,
    output logic              irq
);

    logic [5:0]  req_q;
    logic [31:0] cmd_q;
    logic        cs_en, cs_halt, cs_done, cs_err, cs_nodesc;
    logic        g_err, g_halt, pend_q;
    logic        w_src, w_dst, w_cnt, w_req, w_cs, w_cmd, w_g, w_p, cfg_ok;

    always_comb begin
        w_src  = reg_we && reg_addr == OFS_SRC;
        w_dst  = reg_we && reg_addr == OFS_DST;
        w_cnt  = reg_we && reg_addr == OFS_CNT;
        w_req  = reg_we && reg_addr == OFS_REQ;
        w_cs   = reg_we && reg_addr == OFS_CS;
        w_cmd  = reg_we && reg_addr == OFS_CMD;
        w_g    = reg_we && reg_addr == OFS_GCTL;
        w_p    = reg_we && reg_addr == OFS_PEND;
        cfg_ok = !busy;
        start  = w_cs && reg_wdata[CS_EN] && !busy && !cs_halt && !cs_done
                 && !cs_err && (cnt_q != '0) && g_en;
        cmd    = decode_cmd(cmd_q);
        irq    = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0; dst_q <= '0; cnt_q <= '0; req_q <= '0; cmd_q <= '0;
            cs_en <= 1'b0; cs_halt <= 1'b0; cs_done <= 1'b0; cs_err <= 1'b0;
            cs_nodesc <= 1'b0; g_en <= 1'b0; g_err <= 1'b0; g_halt <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (src_upd)             src_q <= src_nxt;
            else if (w_src && cfg_ok) src_q <= reg_wdata[AW-1:0];
            if (dst_upd)             dst_q <= dst_nxt;
            else if (w_dst && cfg_ok) dst_q <= reg_wdata[AW-1:0];
            if (cnt_dec)             cnt_q <= cnt_q - CW'(1);
            else if (w_cnt && cfg_ok) cnt_q <= reg_wdata[CW-1:0];
            if (w_req && cfg_ok)     req_q <= reg_wdata[5:0];
            if (w_cmd && cfg_ok)     cmd_q <= reg_wdata & CMD_KEEP;

            if (fin_done || fin_err || fin_halt) cs_en <= 1'b0;
            else if (start)                      cs_en <= 1'b1;
            if (w_cs) cs_nodesc <= reg_wdata[CS_NODESC];
            cs_done <= fin_done | (cs_done & ~(w_cs & ~reg_wdata[CS_DONE]));
            cs_halt <= fin_halt | (cs_halt & ~(w_cs & ~reg_wdata[CS_HALT]));
            cs_err  <= fin_err  | (cs_err  & ~(w_cs & ~reg_wdata[CS_ERR]));

            if (w_g) g_en <= reg_wdata[G_EN];
            g_err  <= fin_err  | (g_err  & ~(w_g & ~reg_wdata[G_ERR]));
            g_halt <= fin_halt | (g_halt & ~(w_g & ~reg_wdata[G_HALT]));

            pend_q <= (fin_done & cmd.irq_en) | (pend_q & ~(w_p & ~reg_wdata[CH_IDX]));
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_SRC:  reg_rdata = 32'(src_q);
            OFS_DST:  reg_rdata = 32'(dst_q);
            OFS_CNT:  reg_rdata = 32'(cnt_q);
            OFS_REQ:  reg_rdata = 32'(req_q);
            OFS_CMD:  reg_rdata = cmd_q;
            OFS_CS: begin
                reg_rdata[CS_EN]     = cs_en;
                reg_rdata[CS_HALT]   = cs_halt;
                reg_rdata[CS_DONE]   = cs_done;
                reg_rdata[CS_ERR]    = cs_err;
                reg_rdata[CS_NODESC] = cs_nodesc;
            end
            OFS_GCTL: begin
                reg_rdata[G_EN]   = g_en;
                reg_rdata[G_ERR]  = g_err;
                reg_rdata[G_HALT] = g_halt;
            end
            OFS_PEND: reg_rdata[CH_IDX] = pend_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R3
    en_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_en) |-> g_en && cnt_q != '0);

    // R12
    cnt_steady_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !cnt_dec |=> cnt_q == $past(cnt_q));

    // R7
    done_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_done) |-> cnt_q == '0 && !cs_en);

    // R7
    pend_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> cmd_q[1]);

    // R10
    err_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_err) |-> g_err && cnt_q == $past(cnt_q));

endmodule

// File: rtl/dmach_top.sv
module dmach_top
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              irq
);

    logic [ADDR_W-1:0] src_q, dst_q, src_nxt, dst_nxt;
    logic [CNT_W-1:0]  cnt_q;
    cmd_t              cmd;
    logic              g_en, start, busy, src_upd, dst_upd, cnt_dec;
    logic              fin_done, fin_err, fin_halt;

    dmach_regs #(.AW(ADDR_W), .CW(CNT_W), .CH_IDX(CH_IDX)) regs_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .src_upd(src_upd), .dst_upd(dst_upd), .src_nxt(src_nxt), .dst_nxt(dst_nxt),
        .cnt_dec(cnt_dec), .fin_done(fin_done), .fin_err(fin_err), .fin_halt(fin_halt),
        .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .cmd(cmd), .g_en(g_en),
        .start(start), .irq(irq)
    );

    dmach_engine #(.AW(ADDR_W), .CW(CNT_W)) eng_i (
        .clk(clk), .rst(rst), .start(start), .gen_en(g_en), .cmd(cmd),
        .src(src_q), .dst(dst_q), .cnt(cnt_q), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .busy(busy), .src_upd(src_upd), .dst_upd(dst_upd),
        .src_nxt(src_nxt), .dst_nxt(dst_nxt), .cnt_dec(cnt_dec),
        .fin_done(fin_done), .fin_err(fin_err), .fin_halt(fin_halt)
    );

endmodule

// File: tb/dmach_top_tb_top.sv
module dmach_top_tb_top;

    localparam int CLK_P = 10;
    localparam int CH    = 5;
    localparam int NV    = 8;
    localparam logic [12:0] A_SRC = 13'h000, A_DST = 13'h004, A_CNT = 13'h008,
                            A_REQ = 13'h00C, A_CS = 13'h010, A_CMD = 13'h014,
                            A_GCTL = 13'h1000, A_PEND = 13'h1004;

    // {src[9:0], dst[9:0], count[7:0], command[31:0]}
    localparam logic [59:0] VEC [NV] = '{
        {10'h000, 10'h200, 8'd4, 32'h00C0_0002},   // R4 32-bit units
        {10'h011, 10'h301, 8'd5, 32'h00C0_5102},   // R4 8-bit ports
        {10'h040, 10'h240, 8'd2, 32'h00C0_0302},   // R6 16-byte units
        {10'h082, 10'h282, 8'd3, 32'h0040_A202},   // R5 fixed source
        {10'h0A0, 10'h3F0, 8'd3, 32'h0080_0002},   // R5 fixed destination
        {10'h0C0, 10'h311, 8'd2, 32'h00C0_1002},   // R4 mixed widths
        {10'h0E0, 10'h3A0, 8'd2, 32'h00C0_0702},   // R6 code 7
        {10'h100, 10'h340, 8'd1, 32'h00C0_0502}    // R6 64-byte unit
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [12:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;

    int n_chk = 0, n_err = 0, n_acc = 0, cyc = 0;
    logic [7:0] mem [0:1023];
    logic [7:0] xm  [0:1023];

    always #(CLK_P/2) clk = ~clk;

    dmach_top #(.ADDR_W(32), .CNT_W(24), .CH_IDX(CH)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
    );

    wire [9:0] ma = mem_addr[9:0];
    assign mem_ack = mem_req;

    always_comb begin
        mem_rdata = {mem[ma + 10'd3], mem[ma + 10'd2], mem[ma + 10'd1], mem[ma]};
        if (mem_size == 2'd0)      mem_rdata[31:8]  = '0;
        else if (mem_size == 2'd1) mem_rdata[31:16] = '0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) n_acc <= n_acc + 1;
        if (mem_req && mem_we) begin
            mem[ma] <= mem_wdata[7:0];
            if (mem_size != 2'd0) mem[ma + 10'd1] <= mem_wdata[15:8];
            if (mem_size == 2'd2) begin
                mem[ma + 10'd2] <= mem_wdata[23:16];
                mem[ma + 10'd3] <= mem_wdata[31:24];
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == 100000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(A_CS, v);
            if (!v[0]) break;
        end
    endtask

    task automatic mem_init();
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 8'(i * 7 + 3);
            xm[i]  = 8'(i * 7 + 3);
        end
    endtask

    function automatic int pbytes(input logic [1:0] c);
        return (c == 2'd1) ? 1 : (c == 2'd2) ? 2 : 4;
    endfunction

    function automatic int ubytes(input logic [3:0] c);
        case (c)
            4'd1: return 1;
            4'd2: return 2;
            4'd3: return 16;
            4'd4: return 32;
            4'd5: return 64;
            4'd6: return 128;
            default: return 4;
        endcase
    endfunction

    // expected memory image from the beat rules of R4..R6
    task automatic model(input int s0, input int d0, input int c, input logic [31:0] cmd);
        int s, d, bb, ub, nb;
        s = s0; d = d0;
        ub = ubytes(cmd[11:8]);
        bb = pbytes(cmd[15:14]);
        if (pbytes(cmd[13:12]) < bb) bb = pbytes(cmd[13:12]);
        if (ub < bb) bb = ub;
        nb = c * ub / bb;
        for (int i = 0; i < nb; i++) begin
            for (int k = 0; k < bb; k++) xm[(d + k) & 1023] = xm[(s + k) & 1023];
            if (cmd[23]) s += bb;
            if (cmd[22]) d += bb;
        end
    endtask

    task automatic mem_cmp(input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== xm[i]) bad++;
        chk(tag, 32'(bad), 32'd0);
    endtask

    task automatic launch(input int s, input int d, input int c, input logic [31:0] cmd);
        wr(A_SRC, 32'(s)); wr(A_DST, 32'(d)); wr(A_CNT, 32'(c)); wr(A_CMD, cmd);
        wr(A_CS, 32'h8000_0001);
    endtask

    initial begin
        logic [31:0] v;
        int acc0;
        mem_init();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        foreach (VEC[i]) begin end
        rd(A_SRC, v);  chk("R1 src", v, 0);
        rd(A_DST, v);  chk("R1 dst", v, 0);
        rd(A_CNT, v);  chk("R1 cnt", v, 0);
        rd(A_CS, v);   chk("R1 cs", v, 0);
        rd(A_CMD, v);  chk("R1 cmd", v, 0);
        rd(A_GCTL, v); chk("R1 gctl", v, 0);
        rd(A_PEND, v); chk("R1 pend", v, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 mem_req", 32'(mem_req), 0);

        // R2 / R13 map, masks, truncation
        wr(A_CNT, 32'hFFFF_FFFF); rd(A_CNT, v); chk("R13 count width", v, 32'h00FF_FFFF);
        wr(A_REQ, 32'hFFFF_FFFF); rd(A_REQ, v); chk("R2 request type", v, 32'h3F);
        wr(A_CMD, 32'hFFFF_FFFF); rd(A_CMD, v); chk("R2 command mask", v, 32'h00C0_FF02);
        rd(13'h018, v); chk("R2 offset 0x18", v, 0);
        rd(13'h01C, v); chk("R2 offset 0x1C", v, 0);

        // R3 refused: global enable clear
        acc0 = n_acc;
        launch(0, 'h200, 4, 32'h00C0_0002);
        repeat (5) @(negedge clk);
        rd(A_CS, v); chk("R3 no global enable cs", v, 32'h8000_0000);
        chk("R3 no global enable access", 32'(n_acc), 32'(acc0));
        wr(A_GCTL, 1); rd(A_GCTL, v); chk("R3 global enable readback", v, 1);
        // R3 refused: zero count
        wr(A_CNT, 0); wr(A_CS, 1);
        repeat (5) @(negedge clk);
        rd(A_CS, v); chk("R3 zero count cs", v, 0);
        chk("R3 zero count access", 32'(n_acc), 32'(acc0));

        // table of copies
        for (int i = 0; i < NV; i++) begin
            wr(A_CS, 0); wr(A_PEND, 0);
            mem_init();
            model(int'(VEC[i][59:50]), int'(VEC[i][49:40]), int'(VEC[i][39:32]), VEC[i][31:0]);
            launch(int'(VEC[i][59:50]), int'(VEC[i][49:40]), int'(VEC[i][39:32]), VEC[i][31:0]);
            wait_idle();
            mem_cmp($sformatf("R4 R5 R6 vector %0d memory", i));
            rd(A_CNT, v);  chk($sformatf("R13 vector %0d count", i), v, 0);
            rd(A_CS, v);   chk($sformatf("R7 vector %0d cs", i), v, 32'h8000_0008);
            rd(A_PEND, v); chk($sformatf("R7 vector %0d pend", i), v, 32'(1) << CH);
            chk($sformatf("R7 vector %0d irq", i), 32'(irq), 1);
        end

        // R9 writing 1 keeps the completed flag
        wr(A_CS, 32'h8); rd(A_CS, v); chk("R9 done kept", v, 32'h8);
        // R3 refused while completed is set
        acc0 = n_acc;
        wr(A_CNT, 2); wr(A_CS, 32'h9);
        repeat (5) @(negedge clk);
        rd(A_CS, v); chk("R3 done blocks start", v, 32'h8);
        chk("R3 done blocks access", 32'(n_acc), 32'(acc0));
        wr(A_CS, 0); rd(A_CS, v); chk("R9 done cleared", v, 0);

        // R8 pending
        wr(A_PEND, 32'hFFFF_FFFF); rd(A_PEND, v); chk("R8 write one keeps", v, 32'(1) << CH);
        wr(A_PEND, 0); rd(A_PEND, v); chk("R8 write zero clears", v, 0);
        chk("R8 irq low", 32'(irq), 0);
        wr(A_PEND, 32'hFFFF_FFFF); rd(A_PEND, v); chk("R8 write one never sets", v, 0);

        // R7 interrupt disabled
        wr(A_CS, 0);
        mem_init();
        model('h020, 'h220, 3, 32'h00C0_0000);
        launch('h020, 'h220, 3, 32'h00C0_0000);
        wait_idle();
        mem_cmp("R7 no-irq memory");
        rd(A_CS, v);   chk("R7 no-irq done", v, 32'h8000_0008);
        rd(A_PEND, v); chk("R7 no-irq pend", v, 0);
        chk("R7 no-irq line", 32'(irq), 0);

        // R12 writes during a run are ignored
        wr(A_CS, 0);
        mem_init();
        model(0, 'h200, 20, 32'h00C0_0002);
        launch(0, 'h200, 20, 32'h00C0_0002);
        wr(A_SRC, 3); wr(A_CNT, 1); wr(A_CMD, 0);
        wait_idle();
        mem_cmp("R12 memory unaffected");
        rd(A_SRC, v); chk("R12 R5 final source", v, 32'h50);
        rd(A_CMD, v); chk("R12 command kept", v, 32'h00C0_0002);
        wr(A_CS, 0); wr(A_PEND, 0);

        // R10 misaligned source
        acc0 = n_acc;
        launch(1, 'h200, 3, 32'h00C0_0002);
        repeat (5) @(negedge clk);
        rd(A_CS, v);   chk("R10 cs error", v, 32'h8000_0010);
        rd(A_GCTL, v); chk("R10 global error", v, 32'h5);
        rd(A_CNT, v);  chk("R10 count kept", v, 3);
        chk("R10 no access", 32'(n_acc), 32'(acc0));
        wr(A_CS, 0); wr(A_GCTL, 1);
        rd(A_GCTL, v); chk("R9 global error cleared", v, 1);
        // R10 misaligned 16-bit destination
        launch(0, 'h201, 3, 32'h00C0_2202);
        repeat (5) @(negedge clk);
        rd(A_CS, v); chk("R10 dst misaligned", v, 32'h8000_0010);
        chk("R10 dst no access", 32'(n_acc), 32'(acc0));
        wr(A_CS, 0); wr(A_GCTL, 1);

        // R11 halt by clearing global enable
        mem_init();
        wr(A_SRC, 0); wr(A_DST, 'h200); wr(A_CNT, 20); wr(A_CMD, 32'h00C0_0002);
        wr(A_CS, 1);
        repeat (10) @(negedge clk);
        wr(A_GCTL, 0);
        wait_idle();
        rd(A_CNT, v);  chk("R11 partial count", 32'(v > 0 && v < 20), 1);
        rd(A_CS, v);   chk("R11 cs halted", v, 32'h4);
        rd(A_GCTL, v); chk("R11 global halted", v, 32'h8);
        acc0 = n_acc;
        repeat (10) @(negedge clk);
        chk("R11 stopped", 32'(n_acc), 32'(acc0));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule